// File: doc/BRIEF.md
# Cache Line Maintenance Sequencer

This block is the control engine behind software-requested maintenance of a single data-cache line. It accepts one operation at a time over a valid/ready handshake. Five operations are supported: zero-allocate, zero-set, flush, clean and prefetch touch. In the same cycle it samples the translation result (protection fault, write-through, cache-inhibited and coherence-required page attributes) and the cache state (enabled, locked, hit, hit line dirty, victim dirty). From these it builds a plan and works through it as a fixed sequence of phases.

The phases always run in the same order: victim or line write-back, coherence address broadcast, zero fill, line fill request, line state update, and completion. Each phase is used only if the plan calls for it. Write-back, broadcast and fill talk to an external bus model through request/acknowledge pairs. The zero fill writes the 32-byte line as four 64-bit beats. Completion is a one-cycle pulse that carries an exception code. The tag and data arrays, the bus and address translation all sit outside the block.

Top module: `cbm_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the sequencer is idle. `op_ready` is 1, and every request, update and done output is 0. A reset in the middle of an operation drops any request that is outstanding.
- R2: An operation is accepted when `op_valid` and `op_ready` are both high. The page and cache inputs are sampled in that cycle only. `op_ready` stays low from acceptance until the cycle after a one-cycle `done` pulse.
- R3: A zero fill is four `zero_we` cycles with `zero_beat` counting 0, 1, 2, 3. It is followed directly by a state update with code MOD (1).
- R4: A zero operation (op 0 zero-allocate, op 1 zero-set) that proceeds issues a write-back only when it misses and the victim is dirty. On a hit, or on a miss with a clean victim, there is no write-back.
- R5: When the coherence attribute is set, zero-allocate and zero-set (when they proceed), flush and clean (when they do not fault) each issue one broadcast. When the attribute is clear, no broadcast is issued. Touch never broadcasts.
- R6: Zero-allocate (op 0) completes with no action and exception NONE (0) if any of these holds: the cache is disabled or locked, the page is write-through or cache-inhibited, or there is a protection fault.
- R7: Zero-set (op 1) does no action and completes with ALIGN (1) if the cache is disabled or locked, or if the page is write-through or cache-inhibited. Otherwise it completes with DSI (2) on a protection fault. Both ALIGN conditions outrank the fault.
- R8: Flush (op 2) on a fault does no action and reports DSI. Otherwise a dirty hit writes back and then updates with INVAL (0), a clean hit updates with INVAL only, and a miss does nothing. The cache enable and lock inputs have no effect.
- R9: Clean (op 3) on a fault does no action and reports DSI. Otherwise a dirty hit writes back and then updates with EXCL (2), and a clean hit or a miss makes no update. The cache enable and lock inputs have no effect.
- R10: Touch (op 4) does nothing if any of these holds: a fault, a cache-inhibited page, the lines are locked, the cache is disabled, or the no-prefetch input is set. Otherwise a miss requests a line fill and then updates with REF (3), and a hit updates with REF only. Touch never raises an exception.
- R11: Phases run in the order write-back, broadcast, zero fill, fill, update, done, with at most one active per cycle. A request stays high until its acknowledge is sampled.
- R12: Op codes 5 to 7 complete with no action and exception NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer idle, can accept |
| op_code | input | 3 | 0 zero-alloc, 1 zero-set, 2 flush, 3 clean, 4 touch |
| prot_fault | input | 1 | Translation protection violation |
| pg_wt | input | 1 | Page write-through |
| pg_ci | input | 1 | Page cache-inhibited |
| pg_coh | input | 1 | Page requires coherence broadcast |
| cache_en | input | 1 | Data cache enabled |
| cache_lock | input | 1 | Cache or candidate lines locked |
| no_prefetch | input | 1 | Configuration: ignore touch |
| line_hit | input | 1 | Address hits in the cache |
| hit_dirty | input | 1 | Hit line is modified |
| victim_dirty | input | 1 | Replacement line is modified |
| wb_req | output | 1 | Write-back request |
| wb_ack | input | 1 | Write-back acknowledge |
| bc_req | output | 1 | Coherence broadcast request |
| bc_ack | input | 1 | Broadcast acknowledge |
| fill_req | output | 1 | Line fill request |
| fill_ack | input | 1 | Fill acknowledge |
| zero_we | output | 1 | Zero beat write strobe |
| zero_beat | output | 2 | Beat index of the zero write |
| upd_valid | output | 1 | Line state update strobe |
| upd_code | output | 2 | 0 INVAL, 1 MOD, 2 EXCL, 3 REF |
| done | output | 1 | Operation complete pulse |
| done_exc | output | 2 | 0 NONE, 1 ALIGN, 2 DSI |

## Verification
The hardest cases to reach are the ones where several conditions overlap. Examples are a zero-set that is both locked and faulting, where only the priority decides the outcome, and a zero operation that needs a write-back, a broadcast and all four beats, so that every phase runs in sequence. The bench gets there by sweeping every combination of the ten page and cache inputs for each operation. It varies the acknowledge latency between combinations, and it inverts all inputs right after acceptance to show they were sampled only once. A separate run asserts reset while a write-back request is waiting for its acknowledge.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam logic [2:0] OPC_ZALLOC = 3'd0;
  localparam logic [2:0] OPC_ZSET   = 3'd1;
  localparam logic [2:0] OPC_FLUSH  = 3'd2;
  localparam logic [2:0] OPC_CLEAN  = 3'd3;
  localparam logic [2:0] OPC_TOUCH  = 3'd4;

  localparam logic [1:0] EXC_NONE  = 2'd0;
  localparam logic [1:0] EXC_ALIGN = 2'd1;
  localparam logic [1:0] EXC_DSI   = 2'd2;

  localparam logic [1:0] UPD_INVAL = 2'd0;
  localparam logic [1:0] UPD_MOD   = 2'd1;
  localparam logic [1:0] UPD_EXCL  = 2'd2;
  localparam logic [1:0] UPD_REF   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_WB, S_BC, S_ZERO, S_FILL, S_UPD, S_DONE
  } seq_st_e;

  typedef struct packed {
    logic       wb;
    logic       bc;
    logic       zero;
    logic       fill;
    logic       upd;
    logic [1:0] upd_code;
    logic [1:0] exc;
  } plan_t;
endpackage

// File: rtl/cbm_decide.sv
module cbm_decide
  import cbm_pkg::*;
(
  input  logic [2:0] op,
  input  logic       fault,
  input  logic       wt,
  input  logic       ci,
  input  logic       coh,
  input  logic       en,
  input  logic       lock,
  input  logic       nopf,
  input  logic       hit,
  input  logic       hdirty,
  input  logic       vdirty,
  output plan_t      plan
);
  logic lock_or_off;
  logic wt_or_ci;

  always_comb begin
    lock_or_off = !en || lock;
    wt_or_ci    = wt || ci;
    plan        = '0;
    case (op)
      OPC_ZALLOC, OPC_ZSET: begin
        if (lock_or_off || wt_or_ci) begin
          plan.exc = (op == OPC_ZSET) ? EXC_ALIGN : EXC_NONE;
        end else if (fault) begin
          plan.exc = (op == OPC_ZSET) ? EXC_DSI : EXC_NONE;
        end else begin
          plan.wb       = !hit && vdirty;
          plan.bc       = coh;
          plan.zero     = 1'b1;
          plan.upd      = 1'b1;
          plan.upd_code = UPD_MOD;
        end
      end
      OPC_FLUSH, OPC_CLEAN: begin
        if (fault) begin
          plan.exc = EXC_DSI;
        end else begin
          plan.wb       = hit && hdirty;
          plan.bc       = coh;
          plan.upd      = (op == OPC_FLUSH) ? hit : (hit && hdirty);
          plan.upd_code = (op == OPC_FLUSH) ? UPD_INVAL : UPD_EXCL;
        end
      end
      OPC_TOUCH: begin
        if (!(fault || ci || lock_or_off || nopf)) begin
          plan.fill     = !hit;
          plan.upd      = 1'b1;
          plan.upd_code = UPD_REF;
        end
      end
      default: plan = '0;
    endcase
  end
endmodule

// File: rtl/cbm_beat.sv
module cbm_beat #(
  parameter int unsigned BEATS = 4,
  localparam int unsigned CW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_d;

  assign last = (cnt == CW'(BEATS - 1));

  always_comb begin
    cnt_d = cnt;
    if (run) cnt_d = last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt_d;
  end
endmodule

// File: rtl/cbm_seq.sv
module cbm_seq
  import cbm_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned BEAT_BITS  = 64,
  localparam int unsigned BEATS     = (LINE_BYTES * 8) / BEAT_BITS,
  localparam int unsigned CW        = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [2:0]    op_code,
  input  logic          prot_fault,
  input  logic          pg_wt,
  input  logic          pg_ci,
  input  logic          pg_coh,
  input  logic          cache_en,
  input  logic          cache_lock,
  input  logic          no_prefetch,
  input  logic          line_hit,
  input  logic          hit_dirty,
  input  logic          victim_dirty,
  output logic          wb_req,
  input  logic          wb_ack,
  output logic          bc_req,
  input  logic          bc_ack,
  output logic          fill_req,
  input  logic          fill_ack,
  output logic          zero_we,
  output logic [CW-1:0] zero_beat,
  output logic          upd_valid,
  output logic [1:0]    upd_code,
  output logic          done,
  output logic [1:0]    done_exc
);
  seq_st_e st_q, st_d;
  plan_t   plan_d, plan_q;
  logic    accept;
  logic    beat_last;
  logic [4:0] need_d, need_q;

  cbm_decide u_decide (
    .op(op_code), .fault(prot_fault), .wt(pg_wt), .ci(pg_ci), .coh(pg_coh),
    .en(cache_en), .lock(cache_lock), .nopf(no_prefetch), .hit(line_hit),
    .hdirty(hit_dirty), .vdirty(victim_dirty), .plan(plan_d)
  );

  cbm_beat #(.BEATS(BEATS)) u_beat (
    .clk(clk), .rst_n(rst_n), .run(zero_we), .cnt(zero_beat), .last(beat_last)
  );

  function automatic seq_st_e phase_of(input int idx);
    case (idx)
      0:       phase_of = S_WB;
      1:       phase_of = S_BC;
      2:       phase_of = S_ZERO;
      3:       phase_of = S_FILL;
      default: phase_of = S_UPD;
    endcase
  endfunction

  // lowest-index needed phase at or after 'from', else completion
  function automatic seq_st_e next_phase(input logic [4:0] need, input int from);
    seq_st_e r;
    r = S_DONE;
    for (int i = 4; i >= 0; i--) begin
      if (need[i] && i >= from) r = phase_of(i);
    end
    next_phase = r;
  endfunction

  assign need_d = {plan_d.upd, plan_d.fill, plan_d.zero, plan_d.bc, plan_d.wb};
  assign need_q = {plan_q.upd, plan_q.fill, plan_q.zero, plan_q.bc, plan_q.wb};
  assign accept = op_valid && op_ready;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (accept) st_d = (plan_d.exc != EXC_NONE) ? S_DONE : next_phase(need_d, 0);
      S_WB:   if (wb_ack)    st_d = next_phase(need_q, 1);
      S_BC:   if (bc_ack)    st_d = next_phase(need_q, 2);
      S_ZERO: if (beat_last) st_d = next_phase(need_q, 3);
      S_FILL: if (fill_ack)  st_d = next_phase(need_q, 4);
      S_UPD:  st_d = S_DONE;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      plan_q <= '0;
    else if (accept) plan_q <= plan_d;
  end

  assign op_ready  = (st_q == S_IDLE);
  assign wb_req    = (st_q == S_WB);
  assign bc_req    = (st_q == S_BC);
  assign zero_we   = (st_q == S_ZERO);
  assign fill_req  = (st_q == S_FILL);
  assign upd_valid = (st_q == S_UPD);
  assign upd_code  = upd_valid ? plan_q.upd_code : 2'd0;
  assign done      = (st_q == S_DONE);
  assign done_exc  = done ? plan_q.exc : EXC_NONE;
endmodule

// File: rtl/cbm_seq_chk.sv
module cbm_seq_chk #(
  parameter int unsigned BEATS = 4,
  localparam int unsigned CW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          wb_req,
  input logic          wb_ack,
  input logic          bc_req,
  input logic          bc_ack,
  input logic          fill_req,
  input logic          fill_ack,
  input logic          zero_we,
  input logic [CW-1:0] zero_beat,
  input logic          upd_valid,
  input logic [1:0]    upd_code,
  input logic          done,
  input logic [1:0]    done_exc
);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && op_ready));
  p_one_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_req, bc_req, zero_we, fill_req, upd_valid, done}));
  p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> wb_req);
  p_bc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_req && !bc_ack) |=> bc_req);
  p_fill_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> fill_req);
  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_we && zero_beat != LAST) |=> (zero_we && zero_beat == CW'($past(zero_beat) + 1'b1)));
  p_zero_then_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_we && zero_beat == LAST) |=> (upd_valid && upd_code == 2'd1));
  p_exc_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_exc != 2'd0) |-> $past(op_ready));
  p_wb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(op_ready));
endmodule

bind cbm_seq cbm_seq_chk #(.BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .wb_req(wb_req), .wb_ack(wb_ack), .bc_req(bc_req), .bc_ack(bc_ack),
  .fill_req(fill_req), .fill_ack(fill_ack), .zero_we(zero_we),
  .zero_beat(zero_beat), .upd_valid(upd_valid), .upd_code(upd_code),
  .done(done), .done_exc(done_exc)
);

// File: tb/cbm_seq_tb.sv
module cbm_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [2:0] op_code = '0;
  logic prot_fault = 0, pg_wt = 0, pg_ci = 0, pg_coh = 0, cache_en = 0;
  logic cache_lock = 0, no_prefetch = 0, line_hit = 0, hit_dirty = 0, victim_dirty = 0;
  logic wb_req, bc_req, fill_req, zero_we, upd_valid, done;
  logic wb_ack = 0, bc_ack = 0, fill_ack = 0;
  logic [1:0] zero_beat, upd_code, done_exc;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  cbm_seq u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] v);
    {victim_dirty, hit_dirty, line_hit, no_prefetch, cache_lock, cache_en,
     pg_coh, pg_ci, pg_wt, prot_fault} = v;
  endtask

  // expected behaviour straight from the requirements
  task automatic expect_of(input int op, input logic [9:0] v,
                           output bit e_wb, output bit e_bc, output int e_zb,
                           output bit e_fill, output bit e_upd, output int e_code,
                           output int e_exc);
    bit f, wt, ci, m, en, lk, np, h, hd, vd;
    {vd, hd, h, np, lk, en, m, ci, wt, f} = v;
    e_wb = 0; e_bc = 0; e_zb = 0; e_fill = 0; e_upd = 0; e_code = 0; e_exc = 0;
    if (op == 0 || op == 1) begin
      if (!en || lk || wt || ci) e_exc = (op == 1) ? 1 : 0;
      else if (f) e_exc = (op == 1) ? 2 : 0;
      else begin
        e_wb = !h && vd; e_bc = m; e_zb = 4; e_upd = 1; e_code = 1;
      end
    end else if (op == 2 || op == 3) begin
      if (f) e_exc = 2;
      else begin
        e_wb = h && hd; e_bc = m;
        if (op == 2) begin e_upd = h; e_code = 0; end
        else begin e_upd = h && hd; e_code = 2; end
      end
    end else if (op == 4) begin
      if (!(f || ci || lk || !en || np)) begin
        e_fill = !h; e_upd = 1; e_code = 3;
      end
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input int op, input logic [9:0] v, input int lat);
    bit e_wb, e_bc, e_fill, e_upd;
    int e_zb, e_code, e_exc;
    bit s_wb, s_bc, s_fill, s_upd, s_done, busy_bad, order_bad, beat_bad;
    int zb, code, exc, rank, held, n;
    string t;
    t = tag_of(op);
    expect_of(op, v, e_wb, e_bc, e_zb, e_fill, e_upd, e_code, e_exc);
    s_wb = 0; s_bc = 0; s_fill = 0; s_upd = 0; s_done = 0;
    busy_bad = 0; order_bad = 0; beat_bad = 0;
    zb = 0; code = -1; exc = -1; rank = -1; held = 0; n = 0;
    @(negedge clk);
    op_code = 3'(op); drive(v); op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; drive(~v);  // inputs must have been captured (R2)
    while (!s_done && n < 60) begin
      n++;
      if (op_ready && !done) busy_bad = 1;
      if (wb_req)    begin s_wb = 1;  if (rank > 0) order_bad = 1; rank = 0; end
      if (bc_req)    begin s_bc = 1;  if (rank > 1) order_bad = 1; rank = 1; end
      if (zero_we)   begin if (rank > 2) order_bad = 1; rank = 2;
                           if (int'(zero_beat) != zb) beat_bad = 1; zb++; end
      if (fill_req)  begin s_fill = 1; if (rank > 3) order_bad = 1; rank = 3; end
      if (upd_valid) begin s_upd = 1; code = upd_code; if (rank > 4) order_bad = 1; rank = 4; end
      if (done)      begin s_done = 1; exc = done_exc; end
      if (wb_req || bc_req || fill_req) held++; else held = 0;
      wb_ack   = wb_req   && held > lat;
      bc_ack   = bc_req   && held > lat;
      fill_ack = fill_req && held > lat;
      if (!s_done) @(negedge clk);
    end
    wb_ack = 0; bc_ack = 0; fill_ack = 0;
    chk(s_done, "R2", $sformatf("op%0d v=%h done seen", op, v), s_done, 1);
    if (!s_done) begin
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      return;
    end
    chk(!busy_bad, "R2", $sformatf("op%0d ready low while busy", op), busy_bad, 0);
    chk(!order_bad, "R11", $sformatf("op%0d v=%h phase order", op, v), order_bad, 0);
    chk(s_wb == e_wb, (op < 2) ? "R4" : t, $sformatf("op%0d v=%h writeback", op, v), s_wb, e_wb);
    chk(s_bc == e_bc, "R5", $sformatf("op%0d v=%h broadcast", op, v), s_bc, e_bc);
    chk(zb == e_zb && !beat_bad, "R3", $sformatf("op%0d v=%h zero beats", op, v), zb, e_zb);
    chk(s_fill == e_fill, t, $sformatf("op%0d v=%h fill", op, v), s_fill, e_fill);
    chk(s_upd == e_upd, t, $sformatf("op%0d v=%h update", op, v), s_upd, e_upd);
    if (e_upd) chk(code == e_code, t, $sformatf("op%0d v=%h update code", op, v), code, e_code);
    chk(exc == e_exc, t, $sformatf("op%0d v=%h exception", op, v), exc, e_exc);
  endtask

  task automatic check_idle(input string what);
    chk(op_ready && !wb_req && !bc_req && !fill_req && !zero_we && !upd_valid && !done,
        "R1", what,
        {op_ready, wb_req, bc_req, fill_req, zero_we, upd_valid, done}, 7'b1000000);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check_idle("in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");
    for (int op = 0; op < 5; op++)
      for (int v = 0; v < 1024; v++)
        run_op(op, 10'(v), v % 3);
    for (int op = 5; op < 8; op++)
      for (int v = 0; v < 1024; v += 97)
        run_op(op, 10'(v), 0);
    // reset while a write-back waits for its acknowledge (R1)
    @(negedge clk);
    op_code = 3'd0; drive(10'b1000010000); op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(wb_req, "R4", "writeback pending before reset", wb_req, 1);
    rst_n = 1'b0;
    #1;
    check_idle("reset mid operation");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("released after mid reset");
    run_op(1, 10'b0100010000, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule